// File: doc/BRIEF.md
# Custom Bit-Manipulation Execute Unit

This unit decodes and executes a handful of nonstandard RV32 integer instructions that live in the custom-0 (`0001011`) and custom-1 (`0101011`) major opcodes. Each cycle it may accept one 32-bit instruction word together with the values of its two source registers. The operations are byte reversal, count of leading zeros, count of trailing zeros, and setting or clearing a single bit. For the single-bit operations, the bit number comes either from the instruction's immediate field or from the second source register.

One cycle after an accepted input, the unit presents a 32-bit result, the destination register index, a register write-enable and an illegal-instruction flag. An encoding it does not recognise never writes a register. Register-file access and hazard handling belong to the surrounding pipeline.

Top module: `xbit_unit`

## Requirements
- R1: Opcode `0001011`, funct3 `000`, funct7 `0000000` and instruction bits 24:20 equal to `11000` returns operand A with its four bytes in reverse order.
- R2: Opcode `0001011`, funct3 `010`, funct7 `0000000` and bits 24:20 zero returns the number of trailing zero bits of operand A. The count is 32 when A is zero.
- R3: Opcode `0001011`, funct3 `010`, funct7 `0100000` and bits 24:20 zero returns the number of leading zero bits of operand A. The count is 32 when A is zero.
- R4: Opcode `0001011` with funct3 `001` takes its bit number from bits 24:20. Funct7 `0000000` returns A with that bit cleared, and funct7 `0100000` returns A with that bit set.
- R5: Opcode `0101011` with funct3 `001` takes its bit number from bits 4:0 of operand B and ignores the upper bits of B. Funct7 `0000000` clears the bit and funct7 `0100000` sets it.
- R6: Every other combination of opcode, funct3, funct7 or the fixed bits 24:20 produces the illegal flag high, write-enable low and a zero result.
- R7: A recognised instruction whose rd field (bits 11:7) is zero still produces its result, with write-enable low and the illegal flag low.
- R8: The output-valid signal is high in exactly the cycle after an input-valid cycle. The rd output carries instruction bits 11:7 of that input.
- R9: During reset, and in any cycle when output-valid is low, write-enable and the illegal flag are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An instruction is presented this cycle |
| in_insn | input | 32 | Instruction word |
| in_opa | input | 32 | Value of source register 1 |
| in_opb | input | 32 | Value of source register 2 |
| out_valid | output | 1 | Result of the previous cycle's instruction is present |
| out_data | output | 32 | Result value |
| out_rd | output | 5 | Destination register index |
| out_we | output | 1 | Write the result to out_rd |
| out_illegal | output | 1 | Instruction was not recognised |

## Verification
The assertions assume that `in_valid` and the operands are at defined levels whenever the unit is out of reset. They also assume that the instruction word changes only between clock edges, because the decoder is purely combinational up to the output register. The bench drives every input half a cycle away from the rising edge. It keeps `in_valid` at a known level from time zero, and it applies one mid-run reset that does not coincide with an edge. The illegal encodings it applies each differ from a legal encoding in one field only, so that each field the decoder compares is exercised.

// File: rtl/xbit_pkg.sv
package xbit_pkg;
  localparam int XW   = 32;
  localparam int IDXW = $clog2(XW);
  localparam int NBYT = XW / 8;

  localparam logic [6:0] OPC_CUST0 = 7'b0001011;
  localparam logic [6:0] OPC_CUST1 = 7'b0101011;
  localparam logic [6:0] F7_BASE   = 7'b0000000;
  localparam logic [6:0] F7_ALT    = 7'b0100000;
  localparam logic [4:0] SEL_BSWAP = 5'b11000;

  typedef enum logic [2:0] {
    OP_NONE, OP_BSWAP, OP_CTZ, OP_CLZ, OP_BCLR, OP_BSET
  } xop_e;

  function automatic logic [XW-1:0] f_bswap(input logic [XW-1:0] v);
    logic [XW-1:0] r;
    for (int k = 0; k < NBYT; k++) r[8*k +: 8] = v[8*(NBYT-1-k) +: 8];
    return r;
  endfunction

  function automatic logic [XW-1:0] f_ctz(input logic [XW-1:0] v);
    logic [XW-1:0] n;
    logic hit;
    n = '0;
    hit = 1'b0;
    for (int i = 0; i < XW; i++) begin
      if (!hit) begin
        if (v[i]) hit = 1'b1;
        else n = n + XW'(1);
      end
    end
    return n;
  endfunction

  function automatic logic [XW-1:0] f_clz(input logic [XW-1:0] v);
    logic [XW-1:0] n;
    logic hit;
    n = '0;
    hit = 1'b0;
    for (int i = XW-1; i >= 0; i--) begin
      if (!hit) begin
        if (v[i]) hit = 1'b1;
        else n = n + XW'(1);
      end
    end
    return n;
  endfunction

  function automatic logic [XW-1:0] f_bitedit(input logic [XW-1:0] v,
                                              input logic [IDXW-1:0] idx,
                                              input logic set);
    logic [XW-1:0] m;
    m = XW'(1) << idx;
    return set ? (v | m) : (v & ~m);
  endfunction
endpackage

// File: rtl/xbit_decode.sv
module xbit_decode
  import xbit_pkg::*;
(
  input  logic [31:0]     insn,
  output xop_e            op,
  output logic            idx_from_reg,
  output logic [IDXW-1:0] imm_idx,
  output logic [4:0]      rd
);
  logic [6:0] opc, f7;
  logic [2:0] f3;
  logic [4:0] f_rs2;

  assign opc     = insn[6:0];
  assign rd      = insn[11:7];
  assign f3      = insn[14:12];
  assign f_rs2   = insn[24:20];
  assign f7      = insn[31:25];
  assign imm_idx = f_rs2;

  always_comb begin
    op = OP_NONE;
    idx_from_reg = 1'b0;
    if (opc == OPC_CUST0) begin
      unique case (f3)
        3'b000: if (f7 == F7_BASE && f_rs2 == SEL_BSWAP) op = OP_BSWAP;
        3'b010: if (f_rs2 == 5'd0) begin
          if (f7 == F7_BASE)     op = OP_CTZ;
          else if (f7 == F7_ALT) op = OP_CLZ;
        end
        3'b001: begin
          if (f7 == F7_BASE)     op = OP_BCLR;
          else if (f7 == F7_ALT) op = OP_BSET;
        end
        default: op = OP_NONE;
      endcase
    end else if (opc == OPC_CUST1 && f3 == 3'b001) begin
      idx_from_reg = 1'b1;
      if (f7 == F7_BASE)     op = OP_BCLR;
      else if (f7 == F7_ALT) op = OP_BSET;
    end
  end

  always_comb begin
    if (op == OP_BSWAP) a_r1_bswap_field : assert (insn[24:20] == SEL_BSWAP);
    if (op == OP_CTZ || op == OP_CLZ) a_r2_count_field : assert (insn[24:20] == 5'd0);
  end
endmodule

// File: rtl/xbit_exec.sv
module xbit_exec
  import xbit_pkg::*;
(
  input  xop_e            op,
  input  logic            idx_from_reg,
  input  logic [IDXW-1:0] imm_idx,
  input  logic [XW-1:0]   opa,
  input  logic [XW-1:0]   opb,
  output logic [XW-1:0]   result
);
  logic [IDXW-1:0] bit_idx;
  assign bit_idx = idx_from_reg ? opb[IDXW-1:0] : imm_idx;

  always_comb begin
    unique case (op)
      OP_BSWAP: result = f_bswap(opa);
      OP_CTZ:   result = f_ctz(opa);
      OP_CLZ:   result = f_clz(opa);
      OP_BCLR:  result = f_bitedit(opa, bit_idx, 1'b0);
      OP_BSET:  result = f_bitedit(opa, bit_idx, 1'b1);
      default:  result = '0;
    endcase
  end

  always_comb begin
    if (op == OP_CTZ || op == OP_CLZ) a_r3_count_bound : assert (result <= XW);
    if (op == OP_BCLR || op == OP_BSET) a_r4_one_bit_touched : assert ($countones(result ^ opa) <= 1);
    if (op == OP_BSET) a_r5_bit_now_set : assert (result[bit_idx]);
    if (op == OP_BCLR) a_r5_bit_now_clear : assert (!result[bit_idx]);
  end
endmodule

// File: rtl/xbit_unit.sv
module xbit_unit
  import xbit_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [31:0] in_insn,
  input  logic [31:0] in_opa,
  input  logic [31:0] in_opb,
  output logic        out_valid,
  output logic [31:0] out_data,
  output logic [4:0]  out_rd,
  output logic        out_we,
  output logic        out_illegal
);
  xop_e            dec_op;
  logic            dec_reg_idx;
  logic [IDXW-1:0] dec_imm_idx;
  logic [4:0]      dec_rd;
  logic [XW-1:0]   exe_result;
  logic            dec_known;
  logic            dec_to_x0;

  xbit_decode u_dec (
    .insn(in_insn), .op(dec_op), .idx_from_reg(dec_reg_idx),
    .imm_idx(dec_imm_idx), .rd(dec_rd)
  );

  xbit_exec u_exe (
    .op(dec_op), .idx_from_reg(dec_reg_idx), .imm_idx(dec_imm_idx),
    .opa(in_opa), .opb(in_opb), .result(exe_result)
  );

  assign dec_known = (dec_op != OP_NONE);
  assign dec_to_x0 = (dec_rd == 5'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_data    <= '0;
      out_rd      <= '0;
      out_we      <= 1'b0;
      out_illegal <= 1'b0;
    end else begin
      out_valid   <= in_valid;
      out_we      <= in_valid && dec_known && !dec_to_x0;
      out_illegal <= in_valid && !dec_known;
      if (in_valid) begin
        out_data <= exe_result;
        out_rd   <= dec_rd;
      end
    end
  end

  a_r8_valid_follows : assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r8_no_spurious_valid : assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r8_rd_carried : assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_rd == $past(in_insn[11:7]));
  a_r6_illegal_no_write : assert property (@(posedge clk) disable iff (!rst_n)
    out_illegal |-> !out_we);
  a_r6_illegal_zero_data : assert property (@(posedge clk) disable iff (!rst_n)
    out_illegal |-> out_data == '0);
  a_r7_never_x0 : assert property (@(posedge clk) disable iff (!rst_n)
    out_we |-> out_rd != 5'd0);
  a_r9_flags_gated : assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!out_we && !out_illegal));
endmodule

// File: tb/xbit_unit_bench.sv
`timescale 1ns/1ps
module xbit_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_insn = '0, in_opa = '0, in_opb = '0;
  logic        out_valid, out_we, out_illegal;
  logic [31:0] out_data;
  logic [4:0]  out_rd;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  xbit_unit u_xbit_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_insn(in_insn),
    .in_opa(in_opa), .in_opb(in_opb), .out_valid(out_valid), .out_data(out_data),
    .out_rd(out_rd), .out_we(out_we), .out_illegal(out_illegal)
  );

  typedef struct packed {
    logic [31:0] insn;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] res;
    logic        we;
    logic        ill;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t TAB [NV] = '{
    '{{7'b0000000,5'b11000,5'd1,3'b000,5'd5,7'b0001011}, 32'h12345678, 32'h0, 32'h78563412, 1'b1, 1'b0},
    '{{7'b0000000,5'b00000,5'd1,3'b010,5'd6,7'b0001011}, 32'h00000100, 32'h0, 32'd8,  1'b1, 1'b0},
    '{{7'b0000000,5'b00000,5'd1,3'b010,5'd7,7'b0001011}, 32'h00000000, 32'h0, 32'd32, 1'b1, 1'b0},
    '{{7'b0100000,5'b00000,5'd1,3'b010,5'd8,7'b0001011}, 32'h00010000, 32'h0, 32'd15, 1'b1, 1'b0},
    '{{7'b0100000,5'b00000,5'd1,3'b010,5'd9,7'b0001011}, 32'h00000000, 32'h0, 32'd32, 1'b1, 1'b0},
    '{{7'b0100000,5'b00000,5'd1,3'b010,5'd10,7'b0001011}, 32'h80000000, 32'h0, 32'd0, 1'b1, 1'b0},
    '{{7'b0000000,5'd3,5'd1,3'b001,5'd11,7'b0001011}, 32'hFFFFFFFF, 32'h0, 32'hFFFFFFF7, 1'b1, 1'b0},
    '{{7'b0100000,5'd31,5'd1,3'b001,5'd12,7'b0001011}, 32'h00000000, 32'h0, 32'h80000000, 1'b1, 1'b0},
    '{{7'b0000000,5'd2,5'd1,3'b001,5'd13,7'b0101011}, 32'h000000FF, 32'h00000024, 32'h000000EF, 1'b1, 1'b0},
    '{{7'b0100000,5'd2,5'd1,3'b001,5'd14,7'b0101011}, 32'h00000010, 32'hFFFFFFE0, 32'h00000011, 1'b1, 1'b0},
    '{{7'b0000000,5'b10111,5'd1,3'b000,5'd15,7'b0001011}, 32'h12345678, 32'h0, 32'h0, 1'b0, 1'b1},
    '{{7'b0000000,5'b00000,5'd1,3'b011,5'd16,7'b0001011}, 32'h12345678, 32'h0, 32'h0, 1'b0, 1'b1},
    '{{7'b0000000,5'b00001,5'd1,3'b010,5'd17,7'b0001011}, 32'h00000100, 32'h0, 32'h0, 1'b0, 1'b1},
    '{{7'b0000000,5'd2,5'd1,3'b000,5'd18,7'b0101011}, 32'h000000FF, 32'h1, 32'h0, 1'b0, 1'b1},
    '{{7'b0100001,5'd2,5'd1,3'b001,5'd19,7'b0101011}, 32'h000000FF, 32'h1, 32'h0, 1'b0, 1'b1},
    '{{7'b0000000,5'b11000,5'd1,3'b000,5'd0,7'b0001011}, 32'h12345678, 32'h0, 32'h78563412, 1'b0, 1'b0}
  };

  function automatic string req_of(input int i);
    if (i == 0) return "R1";
    if (i <= 2) return "R2";
    if (i <= 5) return "R3";
    if (i <= 7) return "R4";
    if (i <= 9) return "R5";
    if (i <= 14) return "R6";
    return "R7";
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    check("R9", "reset valid", {31'b0, out_valid}, 32'd0);
    check("R9", "reset we", {31'b0, out_we}, 32'd0);
    check("R9", "reset illegal", {31'b0, out_illegal}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      in_valid = 1'b1;
      in_insn  = TAB[i].insn;
      in_opa   = TAB[i].a;
      in_opb   = TAB[i].b;
      @(negedge clk);
      check("R8", "valid", {31'b0, out_valid}, 32'd1);
      check(req_of(i), "data", out_data, TAB[i].res);
      check(req_of(i), "we", {31'b0, out_we}, {31'b0, TAB[i].we});
      check(req_of(i), "illegal", {31'b0, out_illegal}, {31'b0, TAB[i].ill});
      check("R8", "rd", {27'b0, out_rd}, {27'b0, TAB[i].insn[11:7]});
    end

    // R8/R9: a bubble drops valid and both flags in the following cycle
    in_valid = 1'b0;
    in_insn  = TAB[10].insn;
    @(negedge clk);
    check("R8", "bubble valid", {31'b0, out_valid}, 32'd0);
    check("R9", "bubble we", {31'b0, out_we}, 32'd0);
    check("R9", "bubble illegal", {31'b0, out_illegal}, 32'd0);

    // R5: upper bits of B ignored; index 0 from B = 0xFFFFFFE0 clears bit 0
    in_valid = 1'b1;
    in_insn  = {7'b0000000, 5'd2, 5'd1, 3'b001, 5'd3, 7'b0101011};
    in_opa   = 32'hFFFFFFFF;
    in_opb   = 32'hFFFFFFE0;
    @(negedge clk);
    check("R5", "reg clr bit0", out_data, 32'hFFFFFFFE);

    // R2: trailing count of 0x80000000 is 31
    in_insn = {7'b0000000, 5'b00000, 5'd1, 3'b010, 5'd4, 7'b0001011};
    in_opa  = 32'h80000000;
    @(negedge clk);
    check("R2", "ctz msb", out_data, 32'd31);

    // R9: reset in the middle of a stream clears the outputs
    #1 rst_n = 1'b0;
    #1;
    check("R9", "midrun valid", {31'b0, out_valid}, 32'd0);
    check("R9", "midrun we", {31'b0, out_we}, 32'd0);
    in_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8", "post reset idle", {31'b0, out_valid}, 32'd0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule